// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a software-visible command register and a byte-level I2C engine. Software writes one 16-bit command word. The word may ask for a START with address, a transmit, a receive and a STOP, in any mix. The sequencer runs the requested phases in that fixed order, one engine request at a time. It clears each command bit as its phase completes. It also keeps a 4-bit state code that software reads back together with the command bits and the bus-busy flag.

The engine is driven through a level request that stays high until the engine returns a one-cycle done. Each phase reports its outcome to an interrupt block as a single-cycle event strobe: address or data ACK, NAK, receive done, normal stop, or abnormal stop. The transmit phase can take its bytes from a single byte buffer or from a small pool that is indexed by the sequencer. A STOP that arrives while no transaction is active is reported as abnormal and does not reach the engine.

Top module: `i2cseq_top`

## Requirements
- R1: A command write (cmdWrEn) is taken only when the function-control master enable (fnCtrl bit 0) is 1 and no sequence is running. Otherwise no engine request follows, no event strobes, and the readback bits 15:0 are unchanged. Slave enable (bit 1) alone is not enough.
- R2: The readback cmdRead carries the command bits in 15:0, the busBusy input in bit 16, the state code in bits 22:19, and zero elsewhere. After reset it reads 0.
- R3: Phases run in the order START, transmit, receive, STOP. Only one engine request is outstanding at a time. engReq and engOp stay steady until engDone. The engine operation codes are START 0, SEND 1, RECV 2, STOP 3.
- R4: Command bit 0 requests START. The state code becomes 0xA (repeated start) if bit 3 of the current code is set, and 0x9 otherwise. The address byte (address in 7:1, R/W in 0) comes from byteBuf, or from pool entry 0 when bit 6 (transmit buffer mode) is set. An engine ACK strobes evTxAck and a NAK strobes evTxNak.
- R5: After START, bit 0 is cleared. Bit 1 (transmit) is cleared unless buffer mode is set and poolCount is greater than 1. On a NAK the sequence ends there: the code keeps its start value and the remaining bits stay set. On an ACK the code becomes 0x8 (active).
- R6: In the transmit phase the code is 0xC. Byte mode sends byteBuf once. Buffer mode sends pool entries from index 1 after a START, or from index 0 otherwise, up to poolCount-1, and stops early on a NAK. The phase gives one event (ACK, or NAK). A NAK is followed by an engine STOP op. Bits 1 and 6 are cleared and the code returns to 0x8.
- R7: Receive (bit 3, or bit 4 meaning NACK the last byte) runs only while rxDonePending is 0. It sets code 0xE, requests RECV with engNack equal to bit 4, strobes evRxDone, captures engRxData into rxByte, clears bits 4:3 and returns the code to 0x8. When the phase is skipped, those bits stay set.
- R8: STOP (bit 5) with code bit 3 set moves to code 0xB, requests an engine STOP and strobes evStopOk. With code bit 3 clear it strobes evStopBad and makes no request. In both cases bit 5 is cleared and the code goes to 0x0.
- R9: Event strobes last one cycle, and at most one is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fnCtrl | input | 2 | Function control: bit 0 master enable, bit 1 slave enable |
| cmdWrEn | input | 1 | Command register write strobe |
| cmdWrData | input | 16 | Command word written |
| byteBuf | input | 8 | Single byte buffer (address or data) |
| poolCount | input | IDX_W | Number of pool bytes to send in buffer mode |
| poolByte | input | 8 | Pool entry selected by poolIdx |
| poolIdx | output | IDX_W | Pool read index |
| rxDonePending | input | 1 | Receive-done interrupt still pending |
| busBusy | input | 1 | Bus busy flag from the engine |
| cmdRead | output | 32 | Command register readback |
| rxByte | output | 8 | Last received byte |
| engReq | output | 1 | Engine request, held until engDone |
| engOp | output | 2 | Engine operation code |
| engByte | output | 8 | Byte for START or SEND |
| engNack | output | 1 | NACK the received byte |
| engDone | input | 1 | Engine completion pulse |
| engAck | input | 1 | Slave acknowledged (START/SEND) |
| engRxData | input | 8 | Byte received by the engine |
| evTxAck | output | 1 | Address/data ACK event |
| evTxNak | output | 1 | Address/data NAK event |
| evRxDone | output | 1 | Receive done event |
| evStopOk | output | 1 | Normal stop event |
| evStopBad | output | 1 | Abnormal stop event |

## Verification
The sequencer is driven with several kinds of command words. Writes with the master enable cleared show that the gating holds. Single-phase words isolate each phase. Combined START/transmit/STOP words check the ordering and the dropping of the transmit bit. A NAK on START separates the early end of the sequence from normal completion. The repeated-start code is told apart from the first-start code by issuing START twice. The abnormal stop is told apart from the normal stop by issuing STOP twice in a row. Buffer-mode words with pool counts of 1 and 3, with and without START, and with a NAK in mid-stream, tell apart the starting index, the loop length and the end-of-transfer request. The receive phase is tried both with rxDonePending held and with it low.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [3:0] {
    CODE_IDLE    = 4'h0,
    CODE_ACTIVE  = 4'h8,
    CODE_START   = 4'h9,
    CODE_RESTART = 4'hA,
    CODE_STOP    = 4'hB,
    CODE_TXD     = 4'hC,
    CODE_RXD     = 4'hE
  } seqCode_t;

  typedef enum logic [1:0] {
    ENG_START = 2'd0,
    ENG_SEND  = 2'd1,
    ENG_RECV  = 2'd2,
    ENG_STOP  = 2'd3
  } engOp_t;

  localparam int BIT_START = 0;
  localparam int BIT_MTX   = 1;
  localparam int BIT_MRX   = 3;
  localparam int BIT_LAST  = 4;
  localparam int BIT_STOP  = 5;
  localparam int BIT_TXBUF = 6;

  typedef struct packed {
    logic       loadCmd;
    logic       clrStart;
    logic       clrTx;
    logic       clrTxBuf;
    logic       clrRx;
    logic       clrStop;
    logic       setCode;
    logic [3:0] code;
    logic       idxInc;
    logic       capRx;
  } dpStrobe_t;

endpackage

// File: rtl/i2cseq_datapath.sv
module i2cseq_datapath
  import i2cseq_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [15:0]      wrData,
  input  logic [7:0]       rxIn,
  output logic [15:0]      cmdBits,
  output logic [3:0]       stateCode,
  output logic [IDX_W-1:0] poolIdx,
  output logic [7:0]       rxByte
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdBits <= '0;
    end else if (stb.loadCmd) begin
      cmdBits <= wrData;
    end else begin
      if (stb.clrStart) cmdBits[BIT_START] <= 1'b0;
      if (stb.clrTx)    cmdBits[BIT_MTX]   <= 1'b0;
      if (stb.clrTxBuf) cmdBits[BIT_TXBUF] <= 1'b0;
      if (stb.clrRx)    cmdBits[BIT_LAST:BIT_MRX] <= 2'b00;
      if (stb.clrStop)  cmdBits[BIT_STOP]  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            stateCode <= CODE_IDLE;
    else if (stb.setCode) stateCode <= stb.code;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            poolIdx <= '0;
    else if (stb.loadCmd) poolIdx <= '0;
    else if (stb.idxInc)  poolIdx <= poolIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rxByte <= '0;
    else if (stb.capRx) rxByte <= rxIn;
  end

  // R5: a write always restarts the pool walk from the first entry
  a_r5_idx_restart: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCmd |=> (poolIdx == '0));

endmodule

// File: rtl/i2cseq_control.sv
module i2cseq_control
  import i2cseq_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrEn,
  input  logic [1:0]       fnCtrl,
  input  logic [15:0]      cmdBits,
  input  logic [3:0]       stateCode,
  input  logic [IDX_W-1:0] poolIdx,
  input  logic [IDX_W-1:0] poolCount,
  input  logic             rxDonePending,
  input  logic             engDone,
  input  logic             engAck,
  output dpStrobe_t        stb,
  output logic             engReq,
  output logic [1:0]       engOp,
  output logic             seqIdle,
  output logic             evTxAck,
  output logic             evTxNak,
  output logic             evRxDone,
  output logic             evStopOk,
  output logic             evStopBad
);

  typedef enum logic [2:0] {F_IDLE, F_DISP, F_WAIT, F_GAP, F_ENDX} fsm_t;

  localparam logic [IDX_W-1:0] ONE_BYTE = IDX_W'(1);

  fsm_t   fsm, fsmNxt;
  engOp_t curOp, curOpNxt;

  logic             txBuf, multiTx, lastByte, rxWant;
  logic [IDX_W:0]   nextIdx;

  assign txBuf    = cmdBits[BIT_TXBUF];
  assign multiTx  = txBuf && (poolCount > ONE_BYTE);
  assign nextIdx  = {1'b0, poolIdx} + 1'b1;
  assign lastByte = !txBuf || (nextIdx >= {1'b0, poolCount});
  assign rxWant   = (cmdBits[BIT_MRX] || cmdBits[BIT_LAST]) && !rxDonePending;

  always_comb begin
    stb       = '0;
    fsmNxt    = fsm;
    curOpNxt  = curOp;
    evTxAck   = 1'b0;
    evTxNak   = 1'b0;
    evRxDone  = 1'b0;
    evStopOk  = 1'b0;
    evStopBad = 1'b0;
    unique case (fsm)
      F_IDLE: begin
        if (cmdWrEn && fnCtrl[0]) begin
          stb.loadCmd = 1'b1;
          fsmNxt      = F_DISP;
        end
      end
      F_DISP: begin
        if (cmdBits[BIT_START]) begin
          stb.setCode = 1'b1;
          stb.code    = stateCode[3] ? CODE_RESTART : CODE_START;
          curOpNxt    = ENG_START;
          fsmNxt      = F_WAIT;
        end else if (cmdBits[BIT_MTX]) begin
          stb.setCode = 1'b1;
          stb.code    = CODE_TXD;
          curOpNxt    = ENG_SEND;
          fsmNxt      = F_WAIT;
        end else if (rxWant) begin
          stb.setCode = 1'b1;
          stb.code    = CODE_RXD;
          curOpNxt    = ENG_RECV;
          fsmNxt      = F_WAIT;
        end else if (cmdBits[BIT_STOP]) begin
          stb.setCode = 1'b1;
          if (stateCode[3]) begin
            stb.code = CODE_STOP;
            curOpNxt = ENG_STOP;
            fsmNxt   = F_WAIT;
          end else begin
            stb.code    = CODE_IDLE;
            stb.clrStop = 1'b1;
            evStopBad   = 1'b1;
            fsmNxt      = F_IDLE;
          end
        end else begin
          fsmNxt = F_IDLE;
        end
      end
      F_WAIT: begin
        if (engDone) begin
          unique case (curOp)
            ENG_START: begin
              evTxAck      = engAck;
              evTxNak      = !engAck;
              stb.clrStart = 1'b1;
              stb.clrTx    = !multiTx;
              stb.idxInc   = txBuf;
              if (engAck) begin
                stb.setCode = 1'b1;
                stb.code    = CODE_ACTIVE;
                fsmNxt      = F_DISP;
              end else begin
                fsmNxt = F_IDLE;
              end
            end
            ENG_SEND: begin
              if (engAck && !lastByte) begin
                stb.idxInc = 1'b1;
                fsmNxt     = F_DISP;
              end else begin
                evTxAck      = engAck;
                evTxNak      = !engAck;
                stb.clrTx    = 1'b1;
                stb.clrTxBuf = 1'b1;
                if (engAck) begin
                  stb.setCode = 1'b1;
                  stb.code    = CODE_ACTIVE;
                  fsmNxt      = F_DISP;
                end else begin
                  fsmNxt = F_GAP;
                end
              end
            end
            ENG_RECV: begin
              evRxDone    = 1'b1;
              stb.capRx   = 1'b1;
              stb.clrRx   = 1'b1;
              stb.setCode = 1'b1;
              stb.code    = CODE_ACTIVE;
              fsmNxt      = F_DISP;
            end
            default: begin
              evStopOk    = 1'b1;
              stb.clrStop = 1'b1;
              stb.setCode = 1'b1;
              stb.code    = CODE_IDLE;
              fsmNxt      = F_IDLE;
            end
          endcase
        end
      end
      F_GAP: fsmNxt = F_ENDX;
      default: begin
        if (engDone) begin
          stb.setCode = 1'b1;
          stb.code    = CODE_ACTIVE;
          fsmNxt      = F_DISP;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsm   <= F_IDLE;
      curOp <= ENG_START;
    end else begin
      fsm   <= fsmNxt;
      curOp <= curOpNxt;
    end
  end

  assign engReq  = (fsm == F_WAIT) || (fsm == F_ENDX);
  assign engOp   = (fsm == F_ENDX) ? ENG_STOP : curOp;
  assign seqIdle = (fsm == F_IDLE);

  // R3: a request stays up with the same operation until the engine answers
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (engReq && !engDone) |=> (engReq && $stable(engOp)));

  // R9: never two events in one cycle
  a_r9_one_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evTxAck, evTxNak, evRxDone, evStopOk, evStopBad}));

  // R9: an event is a single-cycle strobe
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rstN)
    evRxDone |=> !evRxDone);

endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
  import i2cseq_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       fnCtrl,
  input  logic             cmdWrEn,
  input  logic [15:0]      cmdWrData,
  input  logic [7:0]       byteBuf,
  input  logic [IDX_W-1:0] poolCount,
  input  logic [7:0]       poolByte,
  output logic [IDX_W-1:0] poolIdx,
  input  logic             rxDonePending,
  input  logic             busBusy,
  output logic [31:0]      cmdRead,
  output logic [7:0]       rxByte,
  output logic             engReq,
  output logic [1:0]       engOp,
  output logic [7:0]       engByte,
  output logic             engNack,
  input  logic             engDone,
  input  logic             engAck,
  input  logic [7:0]       engRxData,
  output logic             evTxAck,
  output logic             evTxNak,
  output logic             evRxDone,
  output logic             evStopOk,
  output logic             evStopBad
);

  dpStrobe_t   stb;
  logic [15:0] cmdBits;
  logic [3:0]  stateCode;
  logic        seqIdle;

  i2cseq_control #(.IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .fnCtrl(fnCtrl),
    .cmdBits(cmdBits), .stateCode(stateCode), .poolIdx(poolIdx),
    .poolCount(poolCount), .rxDonePending(rxDonePending),
    .engDone(engDone), .engAck(engAck), .stb(stb), .engReq(engReq),
    .engOp(engOp), .seqIdle(seqIdle), .evTxAck(evTxAck),
    .evTxNak(evTxNak), .evRxDone(evRxDone), .evStopOk(evStopOk),
    .evStopBad(evStopBad)
  );

  i2cseq_datapath #(.IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(cmdWrData),
    .rxIn(engRxData), .cmdBits(cmdBits), .stateCode(stateCode),
    .poolIdx(poolIdx), .rxByte(rxByte)
  );

  assign engByte = cmdBits[BIT_TXBUF] ? poolByte : byteBuf;
  assign engNack = cmdBits[BIT_LAST];
  assign cmdRead = {9'd0, stateCode, 2'b00, busBusy, cmdBits};

  // R1: a refused write leaves the command bits alone
  a_r1_refused: assert property (@(posedge clk) disable iff (!rstN)
    (seqIdle && cmdWrEn && !fnCtrl[0]) |=> $stable(cmdRead[15:0]));

  // R4: a START request is always accompanied by a start code
  a_r4_start_code: assert property (@(posedge clk) disable iff (!rstN)
    (engReq && engOp == ENG_START) |-> (cmdRead[22:19] == 4'h9 || cmdRead[22:19] == 4'hA));

  // R7: receive completion clears its bits and returns to active
  a_r7_rx_clear: assert property (@(posedge clk) disable iff (!rstN)
    evRxDone |=> (cmdRead[4:3] == 2'b00 && cmdRead[22:19] == 4'h8));

  // R8: either stop outcome leaves the block idle with the stop bit cleared
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    (evStopOk || evStopBad) |=> (cmdRead[22:19] == 4'h0 && !cmdRead[5]));

endmodule

// File: tb/i2cseq_top_test.sv
module i2cseq_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 8;
  localparam int EV_ACK = 0, EV_NAK = 1, EV_RX = 2, EV_OK = 3, EV_BAD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] fnCtrl = 2'b00;
  logic cmdWrEn = 1'b0;
  logic [15:0] cmdWrData = '0;
  logic [7:0] byteBuf = '0;
  logic [IDX_W-1:0] poolCount = '0;
  logic [7:0] poolByte;
  logic [IDX_W-1:0] poolIdx;
  logic rxDonePending = 1'b0;
  logic busBusy = 1'b0;
  logic [31:0] cmdRead;
  logic [7:0] rxByte;
  logic engReq;
  logic [1:0] engOp;
  logic [7:0] engByte;
  logic engNack;
  logic engDone = 1'b0;
  logic engAck = 1'b0;
  logic [7:0] engRxData = '0;
  logic evTxAck, evTxNak, evRxDone, evStopOk, evStopBad;

  logic [7:0] pool [256];
  assign poolByte = pool[poolIdx];

  i2cseq_top #(.IDX_W(IDX_W)) uut (
    .clk(clk), .rstN(rstN), .fnCtrl(fnCtrl), .cmdWrEn(cmdWrEn),
    .cmdWrData(cmdWrData), .byteBuf(byteBuf), .poolCount(poolCount),
    .poolByte(poolByte), .poolIdx(poolIdx), .rxDonePending(rxDonePending),
    .busBusy(busBusy), .cmdRead(cmdRead), .rxByte(rxByte), .engReq(engReq),
    .engOp(engOp), .engByte(engByte), .engNack(engNack), .engDone(engDone),
    .engAck(engAck), .engRxData(engRxData), .evTxAck(evTxAck),
    .evTxNak(evTxNak), .evRxDone(evRxDone), .evStopOk(evStopOk),
    .evStopBad(evStopBad)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  // reference model state
  logic [3:0]  mCode = 4'h0;
  logic [15:0] mCmd = '0;
  logic [7:0]  mRx = '0;
  logic [7:0]  rxVal = '0;
  bit ackPlan[$];
  bit ackQ[$];
  int opQ[$];
  int byteQ[$];
  int nackQ[$];
  int evQ[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit takeAck();
    bit a;
    a = (ackPlan.size() > 0) ? ackPlan.pop_front() : 1'b1;
    ackQ.push_back(a);
    return a;
  endfunction

  function automatic void expOp(input int op, input int b, input int n);
    opQ.push_back(op);
    byteQ.push_back(b);
    nackQ.push_back(n);
  endfunction

  // behavioural prediction of one command write
  task automatic modelCmd(input logic [1:0] fn, input logic [15:0] c, input bit pend);
    int idx;
    bit a;
    bit more;
    logic [7:0] b;
    if (!fn[0]) return;
    mCmd = c;
    idx = 0;
    if (mCmd[0]) begin
      mCode = mCode[3] ? 4'hA : 4'h9;
      b = mCmd[6] ? pool[0] : byteBuf;
      expOp(0, b, 0);
      a = takeAck();
      evQ.push_back(a ? EV_ACK : EV_NAK);
      mCmd[0] = 1'b0;
      if (!(mCmd[6] && poolCount > 1)) mCmd[1] = 1'b0;
      if (mCmd[6]) idx = 1;
      if (!a) return;
      mCode = 4'h8;
    end
    if (mCmd[1]) begin
      mCode = 4'hC;
      more = 1;
      a = 1;
      while (more) begin
        b = mCmd[6] ? pool[idx] : byteBuf;
        expOp(1, b, 0);
        a = takeAck();
        if (mCmd[6] && a && (idx + 1 < int'(poolCount))) idx++;
        else more = 0;
      end
      evQ.push_back(a ? EV_ACK : EV_NAK);
      if (!a) expOp(3, 0, 0);
      mCmd[1] = 1'b0;
      mCmd[6] = 1'b0;
      mCode = 4'h8;
    end
    if ((mCmd[3] || mCmd[4]) && !pend) begin
      expOp(2, 0, mCmd[4]);
      evQ.push_back(EV_RX);
      mRx = rxVal;
      mCmd[4:3] = 2'b00;
      mCode = 4'h8;
    end
    if (mCmd[5]) begin
      if (mCode[3]) begin
        expOp(3, 0, 0);
        evQ.push_back(EV_OK);
      end else begin
        evQ.push_back(EV_BAD);
      end
      mCmd[5] = 1'b0;
      mCode = 4'h0;
    end
  endtask

  task automatic runCmd(input string tag, input logic [1:0] fn, input logic [15:0] c,
                        input bit pend, input bit busy);
    logic [31:0] expRead;
    fnCtrl = fn;
    rxDonePending = pend;
    busBusy = busy;
    modelCmd(fn, c, pend);
    @(posedge clk);
    #2;
    cmdWrEn = 1'b1;
    cmdWrData = c;
    @(posedge clk);
    #2;
    cmdWrEn = 1'b0;
    repeat (60) @(posedge clk);
    #3;
    expRead = {9'd0, mCode, 2'b00, busy, mCmd};
    check(cmdRead == expRead, {tag, " readback"}, cmdRead, expRead);
    check(rxByte == mRx, {tag, " rxByte"}, rxByte, mRx);
    check(opQ.size() == 0, "R3 missing engine request", opQ.size(), 0);
    check(evQ.size() == 0, "R9 missing event", evQ.size(), 0);
    opQ.delete(); byteQ.delete(); nackQ.delete(); evQ.delete(); ackQ.delete(); ackPlan.delete();
  endtask

  // engine responder and request monitor
  initial begin
    int lat;
    bit serving;
    int eo, eb, en;
    string tg;
    serving = 0;
    lat = 0;
    forever begin
      @(posedge clk);
      #2;
      engDone = 1'b0;
      if (serving) begin
        lat--;
        if (lat == 0) begin
          engDone = 1'b1;
          engAck = (engOp <= 2'd1) ? ((ackQ.size() > 0) ? ackQ.pop_front() : 1'b1) : 1'b0;
          engRxData = rxVal;
          serving = 0;
        end
      end else if (engReq && rstN) begin
        serving = 1;
        lat = 2;
        if (opQ.size() == 0) begin
          check(0, "R3 unexpected engine request", engOp, 4);
        end else begin
          eo = opQ.pop_front();
          eb = byteQ.pop_front();
          en = nackQ.pop_front();
          tg = (eo == 0) ? "R4 start op" : (eo == 1) ? "R6 send op" : (eo == 2) ? "R7 recv op" : "R8 stop op";
          check(engOp == eo[1:0], tg, engOp, eo);
          if (eo <= 1) check(engByte == eb[7:0], {tg, " byte"}, engByte, eb);
          if (eo == 2) check(engNack == en[0], {tg, " nack"}, engNack, en);
        end
      end
    end
  end

  // event monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN) begin
      for (int k = 0; k < 5; k++) begin
        bit hit;
        int e;
        hit = (k == EV_ACK) ? evTxAck : (k == EV_NAK) ? evTxNak :
              (k == EV_RX) ? evRxDone : (k == EV_OK) ? evStopOk : evStopBad;
        if (hit) begin
          if (evQ.size() == 0) begin
            check(0, "R9 unexpected event", k, 99);
          end else begin
            e = evQ.pop_front();
            check(e == k, "R9 event order", k, e);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) pool[i] = 8'(i * 7 + 3);
    repeat (3) @(posedge clk);
    #2;
    rstN = 1'b1;
    @(posedge clk);
    #3;
    check(cmdRead == 32'h0, "R2 reset readback", cmdRead, 0);
    check(engReq == 1'b0, "R2 reset no request", engReq, 0);

    // R1: gating by master enable
    runCmd("R1 disabled", 2'b00, 16'h0021, 0, 0);
    runCmd("R1 slave only", 2'b10, 16'h0021, 0, 0);

    // R5: byte mode START+TX+STOP, TX dropped after START
    byteBuf = 8'hA4;
    ackPlan.push_back(1);
    runCmd("R5 start tx stop", 2'b01, 16'h0023, 0, 0);

    // R4: first start then active
    byteBuf = 8'h91;
    ackPlan.push_back(1);
    runCmd("R4 first start", 2'b01, 16'h0001, 0, 0);

    // R5: repeated start refused, rest left set
    ackPlan.push_back(0);
    runCmd("R5 start nak", 2'b01, 16'h0029, 0, 0);

    // R8: normal then abnormal stop
    runCmd("R8 stop normal", 2'b01, 16'h0020, 0, 0);
    runCmd("R8 stop abnormal", 2'b01, 16'h0020, 0, 0);

    // R6: byte mode transmit ack and nak
    ackPlan.push_back(1);
    runCmd("R4 start again", 2'b01, 16'h0001, 0, 0);
    byteBuf = 8'h5C;
    ackPlan.push_back(1);
    runCmd("R6 tx ack", 2'b01, 16'h0002, 0, 0);
    byteBuf = 8'h33;
    ackPlan.push_back(0);
    runCmd("R6 tx nak", 2'b01, 16'h0002, 0, 0);

    // R7: receive last, skipped receive, receive with stop
    rxVal = 8'h6E;
    runCmd("R7 rx last", 2'b01, 16'h0018, 0, 0);
    rxVal = 8'h99;
    runCmd("R7 rx pending R2 busy", 2'b01, 16'h0008, 1, 1);
    rxVal = 8'h17;
    runCmd("R7 rx then stop", 2'b01, 16'h0028, 0, 0);

    // R6: buffer mode
    pool[0] = 8'h50; pool[1] = 8'h11; pool[2] = 8'h22;
    poolCount = 8'd3;
    ackPlan.push_back(1); ackPlan.push_back(1); ackPlan.push_back(1);
    runCmd("R6 pool start tx stop", 2'b01, 16'h0063, 0, 0);
    poolCount = 8'd1;
    ackPlan.push_back(1);
    runCmd("R5 pool single byte", 2'b01, 16'h0043, 0, 0);
    poolCount = 8'd3;
    ackPlan.push_back(1); ackPlan.push_back(1); ackPlan.push_back(1);
    runCmd("R6 pool tx only", 2'b01, 16'h0042, 0, 0);
    ackPlan.push_back(1); ackPlan.push_back(0);
    runCmd("R6 pool nak midway", 2'b01, 16'h0063, 0, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule